// File: doc/BRIEF.md
# Sprite Attribute Copy Engine

This block moves a fixed-length table of sprite attributes from any 256-byte page of the main address space into the sprite attribute window. A single write on the configuration port names the source page and starts the copy. The block needs no further help from the processor. The copy runs as a fixed schedule of slots, each four clocks long. The first slot is an idle warm-up. The next 160 slots each move one byte. A final cool-down slot ends the transfer. From the configuration write to the return to idle takes 645 clocks.

The block sits between the processor and the memory bus. In each copy slot the engine owns the memory port for two clocks: one to fetch the source byte and one to store it. A processor request that arrives in either of those clocks is stalled. Eight clocks into a transfer, the destination window is locked until the transfer ends. Blocked processor reads complete with the value 0xFF. Blocked processor writes complete but never reach memory. All other addresses pass through unchanged. Memory is expected to return read data one clock after the request.

Top module: `sprite_copy_dma`

## Requirements
- R1: A pulse on `cfg_we` starts a transfer from the page on `cfg_page`, with the internal clock count set to zero.
- R2: Slot 0 (count 0 to 3) is a warm-up with no engine access. The first engine access is the fetch of byte 0 at count 4.
- R3: Slot k (1 to 160) fetches source address page*256 + k - 1 and stores that byte at 0xFE00 + k - 1. After a transfer, all 160 destination bytes equal the source bytes.
- R4: Slot k starts at count 4k. The store of slot k happens at count 4k + 2, so stores run from count 6 to count 642. Slot 161 ends the transfer: the lockout drops 645 clocks after the starting write.
- R5: While a transfer runs and the count is 8 or more, processor reads of 0xFE00 to 0xFE9F return 0xFF. At count 7 the window is still readable.
- R6: Processor writes to 0xFE00 to 0xFE9F during the lockout never appear on the memory port.
- R7: Processor accesses outside 0xFE00 to 0xFE9F reach memory normally during a transfer.
- R8: A `cfg_we` pulse during a transfer restarts the whole schedule from slot 0 with the new page. The lockout is released until count 8 of the new schedule.
- R9: When the engine uses the memory port (fetch at phase 0, store at phase 2 of a copy slot), a processor request in that clock gets `cpu_stall` high and is not forwarded.
- R10: After reset the block is idle. It makes no memory access of its own, raises no stall, and lets every address through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Start or restart a transfer |
| cfg_page | input | 8 | Source page number (high address byte) |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | Processor access is a write |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data, valid the clock after acceptance |
| cpu_stall | output | 1 | Processor request not accepted this clock, retry |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one clock after a read request |

## Verification
The assertions check the following on every clock:
- the start condition;
- the clock-by-clock advance of the count and the end of the transfer;
- the quiet warm-up slot;
- each store following its fetch by two clocks;
- blocked window reads never being forwarded;
- outside addresses being forwarded when the engine is idle on the port;
- a single owner on the memory port.

Some behaviours only the bench scenarios can show. One is that all 160 copied bytes arrive intact from the right page. Another is the exact clock at which the lockout opens (count 8) and closes (clock 645). The rest are the swallowing of a blocked write, which is observed on the memory port, and the restart that keeps old data in the window until it is rewritten.

// File: rtl/scd_pkg.sv
package scd_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam logic [DATA_W-1:0] BLOCKED_READ = 8'hFF;

    typedef struct packed {
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_req_t;
endpackage

// File: rtl/scd_sequencer.sv
module scd_sequencer
    import scd_pkg::*;
#(
    parameter int SLOT_LOG2  = 2,
    parameter int COPY_LEN   = 160,
    parameter int LOCK_AFTER = 8,
    parameter logic [ADDR_W-1:0] DEST_BASE = 16'hFE00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_page,
    input  logic [DATA_W-1:0] mem_rdata,
    output bus_req_t          eng_o,
    output logic              lock_o
);
    localparam int LAST_STEP = COPY_LEN + 1;
    localparam int CNT_W     = $clog2((LAST_STEP + 1) << SLOT_LOG2);
    localparam int STEP_W    = CNT_W - SLOT_LOG2;
    localparam logic [CNT_W-1:0]     END_CNT  = CNT_W'(LAST_STEP << SLOT_LOG2);
    localparam logic [CNT_W-1:0]     LOCK_CNT = CNT_W'(LOCK_AFTER);
    localparam logic [CNT_W-1:0]     WARM_END = CNT_W'(1 << SLOT_LOG2);
    localparam logic [STEP_W-1:0]    LAST_CPY = STEP_W'(COPY_LEN);
    localparam logic [STEP_W-1:0]    FIN_STEP = STEP_W'(LAST_STEP);
    localparam logic [SLOT_LOG2-1:0] PH_FETCH = SLOT_LOG2'(0);
    localparam logic [SLOT_LOG2-1:0] PH_CAPT  = SLOT_LOG2'(1);
    localparam logic [SLOT_LOG2-1:0] PH_STORE = SLOT_LOG2'(2);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [7:0]        page;
        logic [DATA_W-1:0] data;
    } seq_state_t;

    seq_state_t state_q, state_d;

    logic [STEP_W-1:0]    step;
    logic [SLOT_LOG2-1:0] phase;
    logic                 in_copy;
    logic [ADDR_W-1:0]    offs;

    always_comb begin
        state_d = state_q;
        eng_o   = '0;
        step    = state_q.cnt[CNT_W-1:SLOT_LOG2];
        phase   = state_q.cnt[SLOT_LOG2-1:0];
        in_copy = (step != '0) && (step <= LAST_CPY);
        offs    = ADDR_W'(step) - ADDR_W'(1);

        if (state_q.active) begin
            state_d.cnt = state_q.cnt + CNT_W'(1);
            if (in_copy && phase == PH_FETCH) begin
                eng_o.req  = 1'b1;
                eng_o.we   = 1'b0;
                eng_o.addr = {state_q.page, 8'h00} + offs;
            end
            if (in_copy && phase == PH_CAPT) begin
                state_d.data = mem_rdata;
            end
            if (in_copy && phase == PH_STORE) begin
                eng_o.req  = 1'b1;
                eng_o.we   = 1'b1;
                eng_o.addr = DEST_BASE + offs;
                eng_o.data = state_q.data;
            end
            if (step == FIN_STEP && phase == PH_FETCH) begin
                state_d.active = 1'b0;
                state_d.cnt    = '0;
            end
        end

        if (cfg_we) begin
            state_d.active = 1'b1;
            state_d.cnt    = '0;
            state_d.page   = cfg_page;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign lock_o = state_q.active && (state_q.cnt >= LOCK_CNT);

    p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (state_q.active && state_q.cnt == '0 && state_q.page == $past(cfg_page)));

    p_warmup_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.active && state_q.cnt < WARM_END) |-> !eng_o.req);

    p_store_after_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_o.req && eng_o.we) |-> ($past(eng_o.req, 2) && !$past(eng_o.we, 2)));

    p_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.active && !cfg_we && state_q.cnt != END_CNT)
        |=> (state_q.active && state_q.cnt == $past(state_q.cnt) + CNT_W'(1)));

    p_finish_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.active && !cfg_we && state_q.cnt == END_CNT) |=> !state_q.active);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.active |-> (!eng_o.req && !lock_o));
endmodule

// File: rtl/scd_filter.sv
module scd_filter
    import scd_pkg::*;
#(
    parameter int COPY_LEN = 160,
    parameter logic [ADDR_W-1:0] DEST_BASE = 16'hFE00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              lock_i,
    input  logic              eng_busy_i,
    input  logic [DATA_W-1:0] mem_rdata,
    output bus_req_t          fwd_o,
    output logic              cpu_stall,
    output logic [DATA_W-1:0] cpu_rdata
);
    localparam logic [ADDR_W:0] WIN_LO = {1'b0, DEST_BASE};
    localparam logic [ADDR_W:0] WIN_HI = WIN_LO + (ADDR_W + 1)'(COPY_LEN);

    typedef struct packed {
        logic rd_blk;
    } flt_state_t;

    flt_state_t state_q, state_d;
    logic in_win;
    logic blocked;

    always_comb begin
        in_win    = ({1'b0, cpu_addr} >= WIN_LO) && ({1'b0, cpu_addr} < WIN_HI);
        blocked   = lock_i && in_win;
        cpu_stall = cpu_req && eng_busy_i;

        fwd_o      = '0;
        fwd_o.req  = cpu_req && !eng_busy_i && !blocked;
        fwd_o.we   = cpu_we;
        fwd_o.addr = cpu_addr;
        fwd_o.data = cpu_wdata;

        state_d.rd_blk = cpu_req && !cpu_we && !eng_busy_i && blocked;
        cpu_rdata      = state_q.rd_blk ? BLOCKED_READ : mem_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    p_block_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && lock_i && in_win) |-> !fwd_o.req);

    p_outside_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !in_win && !eng_busy_i) |-> fwd_o.req);

    p_stall_on_engine_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && eng_busy_i) |-> (cpu_stall && !fwd_o.req));
endmodule

// File: rtl/scd_port_mux.sv
module scd_port_mux
    import scd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bus_req_t          eng_i,
    input  bus_req_t          fwd_i,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    bus_req_t sel;

    always_comb begin
        sel       = eng_i.req ? eng_i : fwd_i;
        mem_req   = sel.req;
        mem_we    = sel.we;
        mem_addr  = sel.addr;
        mem_wdata = sel.data;
    end

    p_one_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_i.req && fwd_i.req));
endmodule

// File: rtl/sprite_copy_dma.sv
module sprite_copy_dma
    import scd_pkg::*;
#(
    parameter int SLOT_LOG2  = 2,
    parameter int COPY_LEN   = 160,
    parameter int LOCK_AFTER = 8,
    parameter logic [15:0] DEST_BASE = 16'hFE00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [7:0]  cfg_page,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    output logic [7:0]  cpu_rdata,
    output logic        cpu_stall,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata
);
    bus_req_t eng;
    bus_req_t fwd;
    logic     lock;

    scd_sequencer #(
        .SLOT_LOG2 (SLOT_LOG2),
        .COPY_LEN  (COPY_LEN),
        .LOCK_AFTER(LOCK_AFTER),
        .DEST_BASE (DEST_BASE)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_page (cfg_page),
        .mem_rdata(mem_rdata),
        .eng_o    (eng),
        .lock_o   (lock)
    );

    scd_filter #(
        .COPY_LEN (COPY_LEN),
        .DEST_BASE(DEST_BASE)
    ) u_flt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .lock_i    (lock),
        .eng_busy_i(eng.req),
        .mem_rdata (mem_rdata),
        .fwd_o     (fwd),
        .cpu_stall (cpu_stall),
        .cpu_rdata (cpu_rdata)
    );

    scd_port_mux u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .eng_i    (eng),
        .fwd_i    (fwd),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata)
    );
endmodule

// File: tb/sprite_copy_dma_tb.sv
`timescale 1ns/1ps
module sprite_copy_dma_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [7:0] cfg_page = '0;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic cpu_stall;
    logic mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = '0;

    always #4 clk = ~clk;

    sprite_copy_dma u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_page(cfg_page),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    logic [7:0] oam  [160];
    logic [7:0] main [1024];

    int n_chk = 0, n_bad = 0;
    int cyc = 0, t0 = 0;
    int wr_seen = 0, first_wr = -1, last_wr = -1;
    int first_acc = -1;
    logic [15:0] first_addr = '0;
    int bad_wr = 0;
    logic [7:0] poison = '0;
    bit finished = 0;

    function automatic logic [7:0] seed(int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    function automatic logic [7:0] src(int pg, int j);
        return seed(((pg & 3) << 8) | j);
    endfunction

    // memory model with one-clock read latency, plus a port monitor
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                if (mem_addr >= 16'hFE00 && mem_addr < 16'hFEA0) begin
                    oam[mem_addr - 16'hFE00] = mem_wdata;
                    wr_seen++;
                    if (first_wr < 0) first_wr = cyc - t0;
                    last_wr = cyc - t0;
                    if (mem_addr == 16'hFE9F && mem_wdata == poison) bad_wr++;
                end else main[mem_addr[9:0]] = mem_wdata;
            end else begin
                if (mem_addr >= 16'hFE00 && mem_addr < 16'hFEA0)
                    mem_rdata <= oam[mem_addr - 16'hFE00];
                else mem_rdata <= main[mem_addr[9:0]];
            end
            if (first_acc < 0) begin
                first_acc  = cyc - t0;
                first_addr = mem_addr;
            end
        end
        cyc++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start(input logic [7:0] pg);
        cfg_we = 1'b1; cfg_page = pg;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        t0 = cyc; wr_seen = 0; first_wr = -1; last_wr = -1; first_acc = -1;
    endtask

    task automatic wait_cnt(input int k);
        while (cyc - t0 < k) @(negedge clk);
    endtask

    task automatic cpu_acc(input bit we, input logic [15:0] a, input logic [7:0] wd,
                           output logic [7:0] rd, output bit st);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        #1;
        st = cpu_stall;
        while (cpu_stall) begin @(negedge clk); #1; end
        @(negedge clk);
        rd = cpu_rdata;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        n_chk++; n_bad++;
        if (!finished) $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        bit st;
        int mism;
        for (int i = 0; i < 1024; i++) main[i] = seed(i);
        for (int i = 0; i < 160; i++) oam[i] = 8'h5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: idle after reset
        check(!cpu_stall && !mem_req, "R10 idle port", {cpu_stall, mem_req}, 0);
        cpu_acc(1'b1, 16'hFE05, 8'h11, rd, st);
        cpu_acc(1'b0, 16'hFE05, 8'h00, rd, st);
        check(rd == 8'h11 && !st, "R10 window open when idle", rd, 8'h11);
        oam[5] = 8'h5A;

        // run A, page 0xC0
        poison = ~src(8'hC0, 159);
        start(8'hC0);
        wait_cnt(7);
        cpu_acc(1'b0, 16'hFE9F, 8'h00, rd, st);
        check(rd == 8'h5A, "R5 count 7 still readable", rd, 8'h5A);
        check(!st, "R9 no stall at phase 3", st, 0);
        cpu_acc(1'b0, 16'hFE9F, 8'h00, rd, st);
        check(st, "R9 stall on engine fetch", st, 1);
        check(rd == 8'hFF, "R5 blocked read", rd, 8'hFF);
        cpu_acc(1'b1, 16'hFE9F, poison, rd, st);
        cpu_acc(1'b1, 16'hC340, 8'h3C, rd, st);
        cpu_acc(1'b0, 16'hC340, 8'h00, rd, st);
        check(rd == 8'h3C, "R7 outside access during copy", rd, 8'h3C);
        wait_cnt(644);
        cpu_acc(1'b0, 16'hFE00, 8'h00, rd, st);
        check(rd == 8'hFF, "R4 locked at clock 644", rd, 8'hFF);
        cpu_acc(1'b0, 16'hFE00, 8'h00, rd, st);
        check(rd == src(8'hC0, 0), "R4 released at clock 645", rd, src(8'hC0, 0));
        mism = 0;
        for (int j = 0; j < 160; j++) if (oam[j] != src(8'hC0, j)) mism++;
        check(mism == 0, "R3 all bytes copied page C0", mism, 0);
        check(wr_seen == 160, "R6 store count (no blocked write)", wr_seen, 160);
        check(bad_wr == 0, "R6 blocked write absent", bad_wr, 0);
        check(first_wr == 6, "R4 first store clock", first_wr, 6);
        check(last_wr == 642, "R4 last store clock", last_wr, 642);
        check(first_acc == 4, "R2 warm-up quiet", first_acc, 4);
        check(first_addr == 16'hC000, "R1 source page latched", first_addr, 16'hC000);

        // run B: restart mid-transfer with page 0xC1
        start(8'hC0);
        wait_cnt(100);
        start(8'hC1);
        wait_cnt(3);
        cpu_acc(1'b0, 16'hFE9F, 8'h00, rd, st);
        check(rd == src(8'hC0, 159), "R8 lock released by restart", rd, src(8'hC0, 159));
        wait_cnt(644);
        cpu_acc(1'b0, 16'hFE00, 8'h00, rd, st);
        check(rd == 8'hFF, "R8 restarted duration", rd, 8'hFF);
        cpu_acc(1'b0, 16'hFE00, 8'h00, rd, st);
        check(rd == src(8'hC1, 0), "R8 restart end", rd, src(8'hC1, 0));
        mism = 0;
        for (int j = 0; j < 160; j++) if (oam[j] != src(8'hC1, j)) mism++;
        check(mism == 0, "R8 all bytes from new page", mism, 0);
        check(wr_seen == 160 && first_wr == 6, "R8 schedule from slot 0", first_wr, 6);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule